// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns one stored frame payload (destination address, source address, type/length field and data, already laid out as bytes in a frame buffer) into a complete Ethernet frame on a 4-bit PHY-side transmit interface. On a start request it produces a fixed header of preamble and start-of-frame delimiter, reads the payload bytes from the buffer in address order, appends zero bytes when the payload is shorter than the minimum frame size, and closes the frame with a CRC-32 frame check sequence that it computes nibble by nibble while the frame goes out.

One nibble leaves per clock, with `tx_en` high for the whole frame. A `busy` bit stays set from the accepted start until the frame has left. A single-cycle `done_irq` pulse marks the end. If the PHY reports a collision while the preamble or delimiter is being sent, both fields still go out in full, and then the frame ends early with `col_flag` set. Retry and backoff are left to the surrounding logic.

Top module: `eth_tx_framer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_en`, `txd`, `busy`, `done_irq`, `col_flag` and `buf_rd` are all 0.
- R2: A `start` seen at a clock edge while `busy` is 0 sets `busy` at that edge. `tx_en` rises one cycle later. The first 16 nibbles are fourteen 0x5 nibbles (seven 0x55 bytes, 10101010 on the wire) followed by 0x5 then 0xD (delimiter byte 0xD5).
- R3: Payload byte k is taken from `buf_data` while `buf_addr` = k (the read is combinational, same cycle), for k = 0 to `frame_len`-1. Each byte is sent low nibble first, so every byte goes out LSB first. `buf_rd` is 0 during the preamble and delimiter. It first goes high in the 17th state cycle after the start.
- R4: When `frame_len` is below 60, zero bytes follow the payload until 60 bytes have been sent after the delimiter. When `frame_len` is 60 or more, no pad bytes are sent.
- R5: The last four bytes are the CRC-32 over payload and pad (reflected polynomial 0x04C11DB7, initial value all ones, final complement), least significant byte first.
- R6: `done_irq` is a one-cycle pulse in the cycle after the final nibble. In that cycle `busy` and `tx_en` are 0.
- R7: A `start` while `busy` is 1 is ignored, and so is any change of `frame_len` after acceptance. The frame in progress is unchanged.
- R8: A `col` pulse during the preamble or delimiter does not shorten them. Exactly 16 nibbles are sent. No buffer read takes place. The frame then ends with `done_irq`, and `col_flag` becomes 1 until the next accepted start.
- R9: A `col` pulse after the delimiter has no effect on the frame, and `col_flag` stays 0.
- R10: `tx_en` is high for one unbroken run per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send the buffered frame |
| frame_len | input | ADDR_W | Payload length in bytes, sampled at acceptance |
| buf_rd | output | 1 | Buffer read strobe, high during the payload phase |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_data | input | 8 | Buffer byte at `buf_addr` (combinational read) |
| col | input | 1 | Collision indication from the PHY |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| busy | output | 1 | Frame in progress |
| done_irq | output | 1 | Transmit-complete pulse |
| col_flag | output | 1 | Last frame ended on a collision in its header |

## Verification
The hardest cases to reach are collisions that fall exactly on the header boundaries. The final delimiter nibble must still lead to an abort, and the first payload nibble must not. Reaching them needs a collision pulse at a chosen state cycle. The bench counts falling edges from the accepting edge and drives `col` for one cycle at indices 3, 15 and 16. It then compares the captured nibble stream with a frame built independently from the payload, padding and a bitwise CRC.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam int          FCS_BYTES     = 4;
    localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Sequencer view of the frame slot currently being emitted
    typedef struct packed {
        tx_state_e  st;
        logic       hi;      // 0: low nibble, 1: high nibble
        logic [1:0] fcs_idx; // byte index within the FCS
    } tx_slot_t;

    // Advance a reflected CRC-32 by four data bits, LSB first
    function automatic logic [31:0] crc_step_nibble(input logic [31:0] crc,
                                                    input logic [3:0]  nib);
        logic [31:0] c;
        c = crc;
        for (int b = 0; b < 4; b++) begin
            if (c[0] ^ nib[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PRE_LEN   = 7,
    parameter int MIN_BYTES = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic [ADDR_W-1:0] frame_len,
    input  logic              col,
    output tx_slot_t          slot,
    output logic [ADDR_W-1:0] pos,
    output logic              buf_rd,
    output logic              last,
    output logic              abort
);

    localparam logic [ADDR_W-1:0] PRE_LAST = ADDR_W'(PRE_LEN - 1);
    localparam logic [ADDR_W-1:0] MIN_LAST = ADDR_W'(MIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] MIN_CNT  = ADDR_W'(MIN_BYTES);
    localparam logic [ADDR_W-1:0] FCS_LAST = ADDR_W'(FCS_BYTES - 1);

    tx_state_e         state_q, state_n;
    logic              hi_q, hi_n;
    logic [ADDR_W-1:0] cnt_q, cnt_n;
    logic [ADDR_W-1:0] len_q, len_n;
    logic              col_seen_q, col_seen_n;

    always_comb begin
        state_n    = state_q;
        hi_n       = hi_q;
        cnt_n      = cnt_q;
        len_n      = len_q;
        col_seen_n = col_seen_q;
        last       = 1'b0;
        abort      = 1'b0;
        if (state_q != ST_IDLE) begin
            hi_n = ~hi_q;
            if (hi_q) cnt_n = cnt_q + 1'b1;
        end
        case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_n    = ST_PRE;
                    hi_n       = 1'b0;
                    cnt_n      = '0;
                    len_n      = frame_len;
                    col_seen_n = 1'b0;
                end
            end
            ST_PRE: begin
                if (col) col_seen_n = 1'b1;
                if (hi_q && cnt_q == PRE_LAST) begin
                    state_n = ST_SFD;
                    cnt_n   = '0;
                end
            end
            ST_SFD: begin
                if (col) col_seen_n = 1'b1;
                if (hi_q) begin
                    cnt_n = '0;
                    if (col_seen_q || col) begin
                        state_n = ST_IDLE;
                        last    = 1'b1;
                        abort   = 1'b1;
                    end else if (len_q == '0) begin
                        state_n = ST_PAD;
                    end else begin
                        state_n = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (hi_q && cnt_q == len_q - 1'b1) begin
                    if (len_q < MIN_CNT) begin
                        state_n = ST_PAD;
                    end else begin
                        state_n = ST_FCS;
                        cnt_n   = '0;
                    end
                end
            end
            ST_PAD: begin
                if (hi_q && cnt_q == MIN_LAST) begin
                    state_n = ST_FCS;
                    cnt_n   = '0;
                end
            end
            ST_FCS: begin
                if (hi_q && cnt_q == FCS_LAST) begin
                    state_n = ST_IDLE;
                    last    = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hi_q       <= 1'b0;
            cnt_q      <= '0;
            len_q      <= '0;
            col_seen_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            hi_q       <= hi_n;
            cnt_q      <= cnt_n;
            len_q      <= len_n;
            col_seen_q <= col_seen_n;
        end
    end

    assign slot.st      = state_q;
    assign slot.hi      = hi_q;
    assign slot.fcs_idx = cnt_q[1:0];
    assign pos          = cnt_q;
    assign buf_rd       = (state_q == ST_DATA);

    // R7: the latched length cannot move while a frame is in flight
    p_len_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(len_q));

    // R2: the preamble never runs past its byte count
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRE) |-> (cnt_q < ADDR_W'(PRE_LEN)));

    // R4: pad bytes only for short payloads, and only up to the minimum
    p_pad_short_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD) |-> (len_q < MIN_CNT && cnt_q < MIN_CNT));

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [3:0]  nib,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  crc_q <= CRC_INIT;
        else if (en)     crc_q <= crc_step_nibble(crc_q, nib);
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/eth_tx_emit.sv
module eth_tx_emit
    import eth_tx_pkg::*;
(
    input  tx_slot_t    slot,
    input  logic [7:0]  buf_data,
    input  logic [31:0] fcs,
    output logic [3:0]  nib,
    output logic        active,
    output logic        crc_en
);

    logic [7:0] cur_byte;

    always_comb begin
        case (slot.st)
            ST_PRE:  cur_byte = PRE_BYTE;
            ST_SFD:  cur_byte = SFD_BYTE;
            ST_DATA: cur_byte = buf_data;
            ST_FCS:  cur_byte = fcs[8*slot.fcs_idx +: 8];
            default: cur_byte = 8'h00;
        endcase
    end

    assign nib    = slot.hi ? cur_byte[7:4] : cur_byte[3:0];
    assign active = (slot.st != ST_IDLE);
    assign crc_en = (slot.st == ST_DATA) || (slot.st == ST_PAD);

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PRE_LEN   = 7,
    parameter int MIN_BYTES = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] frame_len,
    output logic              buf_rd,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              col,
    output logic [3:0]        txd,
    output logic              tx_en,
    output logic              busy,
    output logic              done_irq,
    output logic              col_flag
);

    tx_slot_t    slot;
    logic        start_ok;
    logic        last, abort;
    logic        last_q, abort_q;
    logic [3:0]  nib;
    logic        active, crc_en;
    logic [31:0] fcs;
    logic        busy_q, done_q, col_flag_q;
    logic [3:0]  txd_q;
    logic        tx_en_q;

    assign start_ok = start && !busy_q;

    eth_tx_seq #(
        .ADDR_W   (ADDR_W),
        .PRE_LEN  (PRE_LEN),
        .MIN_BYTES(MIN_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .frame_len(frame_len),
        .col      (col),
        .slot     (slot),
        .pos      (buf_addr),
        .buf_rd   (buf_rd),
        .last     (last),
        .abort    (abort)
    );

    eth_tx_emit u_emit (
        .slot    (slot),
        .buf_data(buf_data),
        .fcs     (fcs),
        .nib     (nib),
        .active  (active),
        .crc_en  (crc_en)
    );

    eth_tx_crc u_crc (
        .clk(clk),
        .rst(rst),
        .clr(start_ok),
        .en (crc_en),
        .nib(nib),
        .fcs(fcs)
    );

    // Output stage: one register between the sequencer and the PHY pins
    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q      <= '0;
            tx_en_q    <= 1'b0;
            last_q     <= 1'b0;
            abort_q    <= 1'b0;
            done_q     <= 1'b0;
            busy_q     <= 1'b0;
            col_flag_q <= 1'b0;
        end else begin
            txd_q   <= active ? nib : 4'h0;
            tx_en_q <= active;
            last_q  <= last;
            abort_q <= abort;
            done_q  <= last_q;
            if (start_ok)    busy_q <= 1'b1;
            else if (last_q) busy_q <= 1'b0;
            if (start_ok)    col_flag_q <= 1'b0;
            else if (last_q) col_flag_q <= abort_q;
        end
    end

    assign txd      = txd_q;
    assign tx_en    = tx_en_q;
    assign busy     = busy_q;
    assign done_irq = done_q;
    assign col_flag = col_flag_q;

    // R6: nothing leaves toward the PHY unless a frame is in progress
    p_en_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> busy);

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    // R6: at completion the interface is quiet and the busy bit is clear
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> (!busy && !tx_en));

    // R3: the first nibble on the wire is never fetched from the buffer
    p_hdr_no_read_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !buf_rd);

    // R8: a collision flag only appears together with completion
    p_colflag_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(col_flag) |-> done_irq);

endmodule

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] frame_len = '0;
    logic          buf_rd;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_data;
    logic          col = 1'b0;
    logic [3:0]    txd;
    logic          tx_en;
    logic          busy;
    logic          done_irq;
    logic          col_flag;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [0:2047];
    logic [3:0] cap [0:4095];
    logic [3:0] exp_n [0:4095];
    int ncap = 0;
    int rises = 0;
    logic en_prev = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign buf_data = mem[buf_addr];

    eth_tx_framer uut (
        .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
        .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_data(buf_data),
        .col(col), .txd(txd), .tx_en(tx_en), .busy(busy),
        .done_irq(done_irq), .col_flag(col_flag)
    );

    always @(negedge clk) begin
        cyc++;
        if (tx_en && !en_prev) rises++;
        en_prev = tx_en;
        if (tx_en && ncap < 4096) begin
            cap[ncap] = txd;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Build the expected nibble stream; returns its length
    function automatic int build_expected(input int len, input bit aborted);
        int n;
        int body;
        logic [7:0] b;
        logic [31:0] c;
        n = 0;
        for (int k = 0; k < 14; k++) begin exp_n[n] = 4'h5; n++; end
        exp_n[n] = 4'h5; n++;
        exp_n[n] = 4'hD; n++;
        if (aborted) return n;
        body = (len < 60) ? 60 : len;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < body; k++) begin
            b = (k < len) ? mem[k] : 8'h00;
            c = crc_byte(c, b);
            exp_n[n] = b[3:0]; n++;
            exp_n[n] = b[7:4]; n++;
        end
        c = ~c;
        for (int k = 0; k < 4; k++) begin
            b = c[8*k +: 8];
            exp_n[n] = b[3:0]; n++;
            exp_n[n] = b[7:4]; n++;
        end
        return n;
    endfunction

    // One frame: optional collision at state index col_at, optional
    // start poke (with a different length) at index poke_at
    task automatic run_frame(input int len, input int col_at, input int poke_at,
                             input string req);
        int i;
        int first_rd;
        int nexp;
        int bad;
        bit aborted;
        aborted = (col_at >= 0 && col_at < 16);
        for (int k = 0; k < len; k++) mem[k] = 8'((k * 37 + len + 5) & 255);
        @(negedge clk);
        ncap = 0;
        rises = 0;
        start = 1'b1;
        frame_len = AW'(len);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after accepted start", int'(busy), 1);
        check(tx_en == 1'b0, "R2", "tx_en one cycle after acceptance", int'(tx_en), 0);
        i = 0;
        first_rd = -1;
        while (!done_irq && i < 5000) begin
            col = (i == col_at);
            if (i == poke_at) begin
                start = 1'b1;
                frame_len = AW'(5);
            end else begin
                start = 1'b0;
            end
            if (buf_rd && first_rd < 0) first_rd = i;
            @(negedge clk);
            i++;
        end
        col = 1'b0;
        start = 1'b0;
        frame_len = AW'(len);
        check(done_irq == 1'b1, "R6", "done_irq seen", int'(done_irq), 1);
        check(busy == 1'b0 && tx_en == 1'b0, "R6", "busy/tx_en at done",
              int'({busy, tx_en}), 0);
        nexp = build_expected(len, aborted);
        check(ncap == nexp, req, "nibble count", ncap, nexp);
        bad = -1;
        for (int k = 0; k < nexp && k < ncap; k++)
            if (bad < 0 && cap[k] !== exp_n[k]) bad = k;
        if (bad >= 0)
            check(1'b0, req, $sformatf("nibble %0d value", bad), int'(cap[bad]), int'(exp_n[bad]));
        else
            check(1'b1, req, "nibble stream", 0, 0);
        check(cap[0] == 4'h5 && cap[15] == 4'hD, "R2", "header first/last nibble",
              int'(cap[15]), 13);
        if (aborted || len == 0)
            check(first_rd == -1, aborted ? "R8" : "R3", "no buffer read", first_rd, -1);
        else
            check(first_rd == 16, "R3", "first buffer read index", first_rd, 16);
        check(col_flag == aborted, aborted ? "R8" : "R9", "col_flag",
              int'(col_flag), int'(aborted));
        check(rises == 1, "R10", "tx_en rising edges", rises, 1);
        @(negedge clk);
        check(done_irq == 1'b0, "R6", "done_irq width", int'(done_irq), 0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({tx_en, txd, busy, done_irq, col_flag, buf_rd} == '0, "R1",
              "outputs in reset", int'({tx_en, txd, busy, done_irq, col_flag, buf_rd}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({tx_en, busy, done_irq, col_flag, buf_rd} == '0, "R1",
              "outputs after reset", int'({tx_en, busy, done_irq, col_flag, buf_rd}), 0);
    endtask

    task automatic test_flag_clear();
        // col_flag is 1 from the previous aborted frame; a new start clears it
        @(negedge clk);
        start = 1'b1;
        frame_len = AW'(20);
        @(negedge clk);
        start = 1'b0;
        check(col_flag == 1'b0, "R8", "col_flag cleared by start", int'(col_flag), 0);
        while (!done_irq) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        run_frame(10, -1, -1, "R4");   // short payload, padded
        run_frame(0, -1, -1, "R4");    // empty payload, all pad
        run_frame(60, -1, -1, "R5");   // exactly minimum, no pad
        run_frame(61, -1, -1, "R5");   // one byte over minimum
        run_frame(100, -1, -1, "R3");  // longer payload
        run_frame(40, -1, 30, "R7");   // start with new length while busy
        run_frame(30, 3, -1, "R8");    // collision in preamble
        test_flag_clear();
        run_frame(30, 15, -1, "R8");   // collision on last delimiter nibble
        run_frame(30, 16, -1, "R9");   // collision on first payload nibble
        run_frame(30, 40, -1, "R9");   // collision deep in payload
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule